// File: doc/BRIEF.md
# Multi-Mode Serial Port

A single-channel serial port whose role is picked by a two-bit mode register. It can run as an asynchronous transmitter/receiver with a 7-bit or 8-bit data frame, or as an 8-bit clock-synchronous shifter acting as clock master or clock slave. All four roles share one shift engine, so at most one transfer is in flight at any time.

Software writes the mode, loads a byte and pulses a start strobe. In the asynchronous roles the bit rate comes from a baud tick input running at an oversampling multiple of the bit rate. The receiver needs no start strobe: it arms itself on a low level of the data input while idle. In master role a clock-enable input paces the shift clock. In slave role the port raises a ready output and waits for an external clock. The polarity of that clock and of the ready output is selectable.

For each pin the block reports whether the serial function owns it. Pins the current role does not use are released to general-purpose I/O.

Top module: `ser_port`

## Requirements
- R1: After reset the mode reads 00 (synchronous master), the port is idle, the data output is high, the shift clock output is low and the done flag is low.
- R2: Mode encoding: 00 synchronous master, 01 synchronous slave, 10 asynchronous with 7 data bits, 11 asynchronous with 8 data bits. A write while idle takes effect on the next clock.
- R3: Data-in and data-out are always owned. The shift clock is owned in modes 00 and 01, and it drives out only in mode 00. The ready pin is owned only in mode 01.
- R4: An asynchronous transmit sends one low start bit, then the data LSB first (7 bits in mode 10, 8 bits in mode 11), then one high stop bit. Each bit lasts OVS baud ticks.
- R5: The asynchronous receiver starts on a low input while idle and samples each bit at its middle. It returns 8 bits in mode 11 and, in mode 10, 7 bits with bit 7 cleared.
- R6: A master transfer produces 8 clock pulses, one per two clock-enable cycles. Output data changes on the falling edge and starts with bit 0. Input data is captured on the rising edge. The clock returns low afterwards, and the received byte is LSB first.
- R7: In slave role, ready asserts after start and deasserts after the first active rising clock edge. The port then shifts 8 bits LSB first, output on the falling edge and input on the rising edge.
- R8: With the polarity bit set, the slave treats a low clock level as active and drives ready active-low.
- R9: A mode write made during a transfer, or in the same cycle as a start, is held back and applied once the port is idle again.
- R10: Done is high for exactly one cycle at the end of every transfer in every mode.
- R11: A start strobe during a transfer is ignored. The frame in flight is unchanged and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_i | input | 2 | Mode value to write |
| pol_neg_i | input | 1 | Slave clock/ready polarity, 1 = active low |
| start_i | input | 1 | Start strobe: load and begin or arm a transfer |
| tx_data_i | input | DW | Byte to send |
| baud_tick_i | input | 1 | Oversampled baud tick (OVS per bit) |
| sclk_en_i | input | 1 | Master clock-enable, one per clock half period |
| sdi_i | input | 1 | Serial data in |
| sclk_i | input | 1 | Shift clock in (slave) |
| sdo_o | output | 1 | Serial data out |
| sclk_o | output | 1 | Shift clock out (master) |
| sclk_oe_o | output | 1 | Shift clock pin drives out |
| rdy_o | output | 1 | Slave ready, polarity per pol_neg_i |
| own_sdi_o | output | 1 | Serial owns data-in pin |
| own_sdo_o | output | 1 | Serial owns data-out pin |
| own_sclk_o | output | 1 | Serial owns shift clock pin |
| own_rdy_o | output | 1 | Serial owns ready pin |
| mode_o | output | 2 | Current mode |
| busy_o | output | 1 | Transfer in flight |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| rx_data_o | output | DW | Last received byte |

## Verification
The bench builds the port with DW=8 and OVS=8. Eight baud ticks per bit are enough for a mid-bit sample to clear the two-flop input synchronizer with a safe margin, and they keep asynchronous frames short. That leaves room in the run for both frame lengths in both directions, master and slave transfers, both slave polarities, a deferred mode write and an ignored start. The 8-bit width lets the 7-bit frame be checked for a cleared top bit.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic [1:0] {
    MODE_MASTER = 2'b00,
    MODE_SLAVE  = 2'b01,
    MODE_ASYNC7 = 2'b10,
    MODE_ASYNC8 = 2'b11
  } ser_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ATX, ST_ARX, ST_MSTR, ST_SLV
  } eng_st_e;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/ser_mode_ctl.sv
module ser_mode_ctl
  import ser_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  logic [1:0] wdata_i,
  input  logic      hold_i,
  output ser_mode_e mode_o,
  output logic      own_sclk_o,
  output logic      own_rdy_o,
  output logic      sclk_oe_o
);
  ser_mode_e mode_q, pend_mode_q;
  logic      pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= MODE_MASTER;
      pend_mode_q <= MODE_MASTER;
      pend_q      <= 1'b0;
    end else if (hold_i) begin
      if (wr_i) begin
        pend_q      <= 1'b1;
        pend_mode_q <= ser_mode_e'(wdata_i);
      end
    end else if (wr_i) begin
      mode_q <= ser_mode_e'(wdata_i);
      pend_q <= 1'b0;
    end else if (pend_q) begin
      mode_q <= pend_mode_q;
      pend_q <= 1'b0;
    end
  end

  always_comb begin
    own_sclk_o = 1'b0;
    own_rdy_o  = 1'b0;
    sclk_oe_o  = 1'b0;
    case (mode_q)
      MODE_MASTER: begin own_sclk_o = 1'b1; sclk_oe_o = 1'b1; end
      MODE_SLAVE:  begin own_sclk_o = 1'b1; own_rdy_o = 1'b1; end
      default: ;
    endcase
  end

  assign mode_o = mode_q;

  assert_mode_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(mode_q));
  assert_pend_apply_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !hold_i && !wr_i) |=> (mode_q == $past(pend_mode_q)));
endmodule

// File: rtl/ser_shift_eng.sv
module ser_shift_eng
  import ser_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ser_mode_e     mode_i,
  input  logic          pol_neg_i,
  input  logic          start_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          baud_tick_i,
  input  logic          mclk_en_i,
  input  logic          sdi_raw_i,
  input  logic          sdi_s_i,
  input  logic          sclk_s_i,
  output logic          sdo_o,
  output logic          mclk_o,
  output logic          rdy_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rx_data_o
);
  localparam int FW   = DW + 2;
  localparam int BCW  = $clog2(FW + 1);
  localparam int TCW  = $clog2(OVS);
  localparam int HALF = OVS / 2;

  eng_st_e        st_q;
  logic [FW-1:0]  sh_q;
  logic [BCW-1:0] bit_q;
  logic [TCW-1:0] tick_q;
  logic           mclk_q, cap_q, rdy_q, done_q, act_q;
  logic [DW-1:0]  rx_q;

  logic           short_f, act, rise, fall, tick_last;
  logic [BCW-1:0] tx_last, rx_last;
  logic [TCW-1:0] rx_pt;
  logic [FW-1:0]  tx_frame;

  always_comb begin
    short_f   = (mode_i == MODE_ASYNC7);
    act       = sclk_s_i ^ pol_neg_i;
    rise      = act & ~act_q;
    fall      = ~act & act_q;
    tick_last = (tick_q == TCW'(OVS - 1));
    tx_last   = short_f ? BCW'(FW - 2) : BCW'(FW - 1);
    rx_last   = short_f ? BCW'(DW) : BCW'(DW + 1);
    rx_pt     = (bit_q == '0) ? TCW'(HALF - 1) : TCW'(OVS - 1);
    tx_frame  = short_f ? {2'b11, tx_data_i[DW-2:0], 1'b0} : {1'b1, tx_data_i, 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sh_q   <= '1;
      bit_q  <= '0;
      tick_q <= '0;
      mclk_q <= 1'b0;
      cap_q  <= 1'b0;
      rdy_q  <= 1'b0;
      done_q <= 1'b0;
      act_q  <= 1'b0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      act_q  <= act;
      case (st_q)
        ST_IDLE: begin
          tick_q <= '0;
          bit_q  <= '0;
          if (start_i) begin
            case (mode_i)
              MODE_MASTER: begin sh_q <= {2'b11, tx_data_i}; mclk_q <= 1'b0; st_q <= ST_MSTR; end
              MODE_SLAVE:  begin sh_q <= {2'b11, tx_data_i}; rdy_q <= 1'b1;  st_q <= ST_SLV;  end
              default:     begin sh_q <= tx_frame; st_q <= ST_ATX; end
            endcase
          end else if (mode_i[1] && !sdi_s_i) begin
            st_q <= ST_ARX;
          end
        end
        ST_ATX: if (baud_tick_i) begin
          if (tick_last) begin
            tick_q <= '0;
            if (bit_q == tx_last) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              sh_q  <= {1'b1, sh_q[FW-1:1]};
              bit_q <= bit_q + 1'b1;
            end
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
        ST_ARX: if (baud_tick_i) begin
          if (tick_q == rx_pt) begin
            tick_q <= '0;
            if (bit_q == rx_last) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
              rx_q   <= short_f ? {1'b0, sh_q[DW-1:1]} : sh_q[DW-1:0];
            end else begin
              if (bit_q != '0) sh_q[DW-1:0] <= {sdi_s_i, sh_q[DW-1:1]};
              bit_q <= bit_q + 1'b1;
            end
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
        ST_MSTR: if (mclk_en_i) begin
          if (!mclk_q) begin
            mclk_q <= 1'b1;
            cap_q  <= sdi_raw_i;
          end else begin
            mclk_q       <= 1'b0;
            sh_q[DW-1:0] <= {cap_q, sh_q[DW-1:1]};
            if (bit_q == BCW'(DW - 1)) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
              rx_q   <= {cap_q, sh_q[DW-1:1]};
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        ST_SLV: begin
          if (rise) begin
            cap_q <= sdi_s_i;
            rdy_q <= 1'b0;
          end
          if (fall && !rdy_q) begin
            sh_q[DW-1:0] <= {cap_q, sh_q[DW-1:1]};
            if (bit_q == BCW'(DW - 1)) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
              rx_q   <= {cap_q, sh_q[DW-1:1]};
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sdo_o     = (st_q == ST_ATX || st_q == ST_MSTR || st_q == ST_SLV) ? sh_q[0] : 1'b1;
  assign mclk_o    = mclk_q;
  assign rdy_o     = rdy_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign rx_data_o = rx_q;

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_rdy_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SLV && rise) |=> !rdy_q);
  assert_mclk_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_MSTR) |-> !mclk_q);
  assert_tx_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && start_i && mode_i[1]) |=> (st_q == ST_ATX && !sdo_o));
  assert_start_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ATX && start_i && !baud_tick_i) |=> $stable(sh_q));
endmodule

// File: rtl/ser_port.sv
module ser_port
  import ser_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_wr_i,
  input  logic [1:0]    mode_i,
  input  logic          pol_neg_i,
  input  logic          start_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          baud_tick_i,
  input  logic          sclk_en_i,
  input  logic          sdi_i,
  input  logic          sclk_i,
  output logic          sdo_o,
  output logic          sclk_o,
  output logic          sclk_oe_o,
  output logic          rdy_o,
  output logic          own_sdi_o,
  output logic          own_sdo_o,
  output logic          own_sclk_o,
  output logic          own_rdy_o,
  output logic [1:0]    mode_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rx_data_o
);
  ser_mode_e  mode;
  logic [1:0] sync_q;
  logic       eng_busy, eng_rdy;

  ser_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, sdi_i}),
    .q_o   (sync_q)
  );

  ser_mode_ctl u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (mode_wr_i),
    .wdata_i   (mode_i),
    .hold_i    (eng_busy | start_i),
    .mode_o    (mode),
    .own_sclk_o(own_sclk_o),
    .own_rdy_o (own_rdy_o),
    .sclk_oe_o (sclk_oe_o)
  );

  ser_shift_eng #(.DW(DW), .OVS(OVS)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .pol_neg_i  (pol_neg_i),
    .start_i    (start_i),
    .tx_data_i  (tx_data_i),
    .baud_tick_i(baud_tick_i),
    .mclk_en_i  (sclk_en_i),
    .sdi_raw_i  (sdi_i),
    .sdi_s_i    (sync_q[0]),
    .sclk_s_i   (sync_q[1]),
    .sdo_o      (sdo_o),
    .mclk_o     (sclk_o),
    .rdy_o      (eng_rdy),
    .busy_o     (eng_busy),
    .done_o     (done_o),
    .rx_data_o  (rx_data_o)
  );

  assign rdy_o     = eng_rdy ^ pol_neg_i;
  assign own_sdi_o = 1'b1;
  assign own_sdo_o = 1'b1;
  assign mode_o    = mode;
  assign busy_o    = eng_busy;
endmodule

// File: tb/ser_port_test.sv
`timescale 1ns/1ps
module ser_port_test;
  localparam int DW  = 8;
  localparam int OVS = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_wr = 0, pol_neg = 0, start = 0, baud_tick = 1, sclk_en = 1, sdi = 1, sclk_in = 0;
  logic [1:0] mode_v = 0;
  logic [DW-1:0] tx_data = 0;
  logic sdo, sclk_out, sclk_oe, rdy, own_sdi, own_sdo, own_sclk, own_rdy, busy, done;
  logic [1:0] mode_rd;
  logic [DW-1:0] rx_data;

  int n_chk = 0, n_fail = 0;
  int exp_mode = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ser_port #(.DW(DW), .OVS(OVS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_wr_i(mode_wr), .mode_i(mode_v), .pol_neg_i(pol_neg),
    .start_i(start), .tx_data_i(tx_data), .baud_tick_i(baud_tick), .sclk_en_i(sclk_en),
    .sdi_i(sdi), .sclk_i(sclk_in), .sdo_o(sdo), .sclk_o(sclk_out), .sclk_oe_o(sclk_oe),
    .rdy_o(rdy), .own_sdi_o(own_sdi), .own_sdo_o(own_sdo), .own_sclk_o(own_sclk),
    .own_rdy_o(own_rdy), .mode_o(mode_rd), .busy_o(busy), .done_o(done), .rx_data_o(rx_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock model of mode and pin ownership (R2, R3)
  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin
      chk("R2 mode", int'(mode_rd), exp_mode);
      chk("R3 own_sdi", int'(own_sdi), 1);
      chk("R3 own_sdo", int'(own_sdo), 1);
      chk("R3 own_sclk", int'(own_sclk), int'(exp_mode == 0 || exp_mode == 1));
      chk("R3 sclk_oe", int'(sclk_oe), int'(exp_mode == 0));
      chk("R3 own_rdy", int'(own_rdy), int'(exp_mode == 1));
    end
  end

  task automatic set_mode(input int m);
    @(negedge clk);
    mode_wr = 1; mode_v = 2'(m); exp_mode = m;
    @(negedge clk);
    mode_wr = 0;
    chk("R2 write", int'(mode_rd), m);
  endtask

  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] slv, input bit defer);
    int pulses = 0;
    logic prev = 0;
    @(negedge clk);
    start = 1; tx_data = tx; sdi = slv[0];
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      start = 0;
      if (k % 2 == 1) begin
        chk("R6 sdo bit", int'(sdo), int'(tx[(k-1)/2]));
        sdi = slv[(k-1)/2];
      end
      if (sclk_out && !prev) pulses++;
      prev = sclk_out;
      chk("R10 done early", int'(done), 0);
      if (defer && k == 5) begin mode_wr = 1; mode_v = 2'b11; end
      if (defer && k == 6) mode_wr = 0;
      if (defer && k == 10) chk("R9 mode held", int'(mode_rd), 0);
    end
    @(negedge clk);
    chk("R10 done", int'(done), 1);
    chk("R6 sclk idle", int'(sclk_out), 0);
    chk("R6 pulses", pulses, 8);
    chk("R6 rx", int'(rx_data), int'(slv));
    sdi = 1;
    if (defer) exp_mode = 3;
    @(negedge clk);
    chk("R10 one cycle", int'(done), 0);
    if (defer) chk("R9 mode applied", int'(mode_rd), 3);
  endtask

  task automatic async_tx(input logic [7:0] tx, input int bits, input bit poke);
    int nb = bits + 2;
    int b, e;
    @(negedge clk);
    start = 1; tx_data = tx;
    for (int k = 1; k <= nb * OVS + 1; k++) begin
      @(negedge clk);
      start = 0;
      if ((k - 1) % OVS == OVS / 2) begin
        b = (k - 1) / OVS;
        e = (b == 0) ? 0 : (b <= bits) ? int'(tx[b-1]) : 1;
        chk("R4 frame bit", int'(sdo), e);
      end
      if (poke && k == 2 * OVS) begin start = 1; tx_data = ~tx; end
      if (k == nb * OVS + 1) chk("R10 tx done", int'(done), 1);
    end
    @(negedge clk);
    chk("R10 tx one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    chk("R11 no second transfer", int'(busy), 0);
    chk("R4 idle high", int'(sdo), 1);
  endtask

  task automatic async_rx(input logic [7:0] d, input int bits);
    int seen = 0;
    logic [7:0] got = 0;
    logic [7:0] exp_d;
    exp_d = (bits == 7) ? {1'b0, d[6:0]} : d;
    for (int b = 0; b < bits + 2 + 2; b++) begin
      for (int c = 0; c < OVS; c++) begin
        @(negedge clk);
        if (done) begin seen++; got = rx_data; end
        if (c == 0) sdi = (b == 0) ? 1'b0 : (b <= bits) ? d[b-1] : 1'b1;
      end
    end
    chk("R10 rx done count", seen, 1);
    chk("R5 rx data", int'(got), int'(exp_d));
  endtask

  task automatic slave_xfer(input logic [7:0] tx, input logic [7:0] mst, input bit neg);
    int seen = 0;
    localparam int H = 5;
    @(negedge clk);
    start = 1; tx_data = tx;
    @(negedge clk);
    start = 0;
    chk("R7 R8 ready active", int'(rdy), neg ? 0 : 1);
    for (int b = 0; b < 8; b++) begin
      sdi = mst[b];
      repeat (H) @(negedge clk);
      chk("R7 slave sdo", int'(sdo), int'(tx[b]));
      sclk_in = ~neg;
      repeat (H) begin
        @(negedge clk);
        if (done) seen++;
      end
      if (b == 0) chk("R7 R8 ready dropped", int'(rdy), neg ? 1 : 0);
      sclk_in = neg;
    end
    repeat (H + 3) begin
      @(negedge clk);
      if (done) seen++;
    end
    chk("R10 slave done count", seen, 1);
    chk("R7 slave rx", int'(rx_data), int'(mst));
    chk("R8 ready idle", int'(rdy), neg ? 1 : 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 mode", int'(mode_rd), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 sdo", int'(sdo), 1);
    chk("R1 sclk", int'(sclk_out), 0);
    chk("R1 done", int'(done), 0);

    master_xfer(8'hA5, 8'h3C, 0);
    master_xfer(8'h01, 8'hFE, 1);
    repeat (4) @(negedge clk);
    async_tx(8'hC3, 8, 1);
    async_rx(8'h96, 8);
    set_mode(2);
    async_tx(8'h5A, 7, 0);
    async_rx(8'hCD, 7);
    set_mode(1);
    repeat (4) @(negedge clk);
    slave_xfer(8'h6E, 8'hB1, 0);
    @(negedge clk);
    pol_neg = 1; sclk_in = 1;
    repeat (6) @(negedge clk);
    slave_xfer(8'h93, 8'h2C, 1);
    set_mode(0);
    repeat (3) @(negedge clk);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule